// File: doc/BRIEF.md
# Line Oscillator Calibration Sequencer

This block sequences the digital frequency control of a line oscillator inside a television sync processor. Out of power-on reset it parks the oscillator control word at its highest code, so that the line oscillator runs above the 6.75 MHz nominal and the horizontal output stage stays safe. The oscillator stays there until software has written the crystal setting register and then the control register, in that order. The control register write starts a calibration. During calibration each measurement strobe carries the number of oscillator cycles counted in one reference window. The control word steps down by one for every measurement that is still above the target count. The calibration ends as soon as a measurement is at or below the target.

Once calibrated, the sequencer watches the lock detector. A loss of lock restarts the calibration from the safe code. The block also picks the phase-loop time constant: forced fast, forced slow, or chosen automatically from the noise and lock flags. It also drives a loop-open flag, which lets the line frequency free-run at its calibrated value.

The controller has four states. SAFE is entered from reset. ARMED is entered when a crystal write arrives in SAFE. CAL is entered on a control write in ARMED, or on loss of lock in RUN. RUN is entered from CAL when a measurement reaches the target, or when the control word reaches zero.

Top module: `line_osc_cal_seq`

## Requirements
- R1: After reset `ctrl_word` is all ones (the safe code above nominal), `cal_busy` is 0, `loop_open` is 0 and `xtal_sel` is 0.
- R2: A write to subaddress 0 stores `wr_data[1:0]` on `xtal_sel` from the next cycle. In SAFE it moves the controller to ARMED.
- R3: A write to subaddress 1 while in SAFE, before any subaddress 0 write since reset, is ignored. `cal_busy` stays 0, `ctrl_word` stays all ones, and the loop-open and time-constant settings do not change.
- R4: A write to subaddress 1 in ARMED enters CAL. From the next cycle `cal_busy` is 1 and `ctrl_word` is all ones.
- R5: In CAL, each cycle with `meas_valid` high, `meas_cnt` > TARGET_CNT and `ctrl_word` non-zero lowers `ctrl_word` by exactly one.
- R6: In CAL, a cycle with `meas_valid` high and either `meas_cnt` <= TARGET_CNT or `ctrl_word` zero enters RUN. `cal_busy` falls on the next cycle and `ctrl_word` holds its value.
- R7: In RUN, `in_lock` low enters CAL. The next cycle shows `cal_busy` 1 and `ctrl_word` all ones. In CAL, `in_lock` has no effect on the state.
- R8: The mode field `wr_data[1:0]` of an accepted subaddress 1 write forces `tc_sel`. Code 01 gives fast (`tc_sel` = 2'b10). Code 10 gives slow (2'b00).
- R9: Mode codes 00 and 11 select automatic. Here `tc_sel` is slow (2'b00) when `noisy` is high. It is medium (2'b01) when `noisy` is low and `in_lock` is low. It is slow when `noisy` is low and `in_lock` is high.
- R10: `loop_open` follows `wr_data[2]` of the last accepted subaddress 1 write.
- R11: A subaddress 1 write in CAL or RUN updates mode and loop-open without starting a calibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wr_stb | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register subaddress |
| wr_data | input | DATA_W | Register write data |
| meas_valid | input | 1 | Frequency measurement valid |
| meas_cnt | input | CNT_W | Oscillator cycles in one reference window |
| in_lock | input | 1 | Coincidence detector reports lock |
| noisy | input | 1 | Input signal is noisy |
| ctrl_word | output | CW_W | Oscillator frequency control word |
| cal_busy | output | 1 | Calibration in progress |
| tc_sel | output | 2 | Loop time constant: 00 slow, 01 medium, 10 fast |
| loop_open | output | 1 | Phase loop opened |
| xtal_sel | output | XTAL_W | Stored crystal indication |

## Verification
The bench sweeps an oscillator model whose count is linear in the control word. Some offsets put the target exactly on the safe code, so the calibration takes zero steps. Other offsets land midway, and one never reaches the target, so the word has to stop at zero. A design that decrements once too often, or steps past zero, ends on the wrong word. A control write made before the crystal write is issued deliberately: a design that does not enforce the order would start calibrating too early or pick up the ignored mode bits. Loss of lock is raised after each calibration, and a design that resumes from the current word instead of the safe code fails the sweep. All combinations of time-constant mode, noise and lock are checked against the selection table.

// File: rtl/lo_cal_pkg.sv
package lo_cal_pkg;
    typedef enum logic [1:0] {
        ST_SAFE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_CAL   = 2'd2,
        ST_RUN   = 2'd3
    } cal_state_t;

    typedef enum logic [1:0] {
        TC_SLOW   = 2'b00,
        TC_MEDIUM = 2'b01,
        TC_FAST   = 2'b10
    } tc_t;

    localparam int SUB_XTAL = 0;
    localparam int SUB_CTRL = 1;
    localparam logic [1:0] MODE_FAST = 2'b01;
    localparam logic [1:0] MODE_SLOW = 2'b10;
endpackage

// File: rtl/lo_cal_regs.sv
module lo_cal_regs #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int XTAL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              armed,
    output logic              wr_xtal,
    output logic              wr_ctrl,
    output logic [XTAL_W-1:0] xtal_sel,
    output logic [1:0]        mode,
    output logic              loop_open
);
    import lo_cal_pkg::*;

    always_comb begin
        wr_xtal = wr_stb && (wr_addr == ADDR_W'(SUB_XTAL));
        wr_ctrl = wr_stb && (wr_addr == ADDR_W'(SUB_CTRL));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xtal_sel  <= '0;
            mode      <= '0;
            loop_open <= 1'b0;
        end else begin
            if (wr_xtal)
                xtal_sel <= wr_data[XTAL_W-1:0];
            if (wr_ctrl && armed) begin
                mode      <= wr_data[1:0];
                loop_open <= wr_data[2];
            end
        end
    end
endmodule

// File: rtl/lo_cal_fsm.sv
module lo_cal_fsm #(
    parameter int CW_W       = 6,
    parameter int CNT_W      = 10,
    parameter int TARGET_CNT = 432
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_xtal,
    input  logic                     wr_ctrl,
    input  logic                     meas_valid,
    input  logic [CNT_W-1:0]         meas_cnt,
    input  logic                     in_lock,
    output lo_cal_pkg::cal_state_t   state,
    output logic [CW_W-1:0]          ctrl_word,
    output logic                     cal_busy,
    output logic                     armed
);
    import lo_cal_pkg::*;

    localparam logic [CW_W-1:0]  SAFE_CW = {CW_W{1'b1}};
    localparam logic [CNT_W-1:0] TGT     = CNT_W'(TARGET_CNT);

    cal_state_t next_state;
    logic       above_tgt;
    logic       cal_done;
    logic       cal_enter;

    always_comb begin
        above_tgt = meas_cnt > TGT;
        cal_done  = meas_valid && (!above_tgt || ctrl_word == '0);
    end

    always_comb begin
        next_state = state;
        unique case (state)
            ST_SAFE:  if (wr_xtal)   next_state = ST_ARMED;
            ST_ARMED: if (wr_ctrl)   next_state = ST_CAL;
            ST_CAL:   if (cal_done)  next_state = ST_RUN;
            ST_RUN:   if (!in_lock)  next_state = ST_CAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_SAFE;
        else        state <= next_state;
    end

    always_comb cal_enter = (next_state == ST_CAL) && (state != ST_CAL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_word <= SAFE_CW;
        else if (cal_enter)
            ctrl_word <= SAFE_CW;
        else if (state == ST_CAL && meas_valid && above_tgt && ctrl_word != '0)
            ctrl_word <= ctrl_word - 1'b1;
    end

    always_comb begin
        cal_busy = 1'b0;
        armed    = 1'b0;
        unique case (state)
            ST_SAFE:  begin cal_busy = 1'b0; armed = 1'b0; end
            ST_ARMED: begin cal_busy = 1'b0; armed = 1'b1; end
            ST_CAL:   begin cal_busy = 1'b1; armed = 1'b1; end
            ST_RUN:   begin cal_busy = 1'b0; armed = 1'b1; end
        endcase
    end
endmodule

// File: rtl/lo_cal_tcsel.sv
module lo_cal_tcsel (
    input  logic       [1:0] mode,
    input  logic             noisy,
    input  logic             in_lock,
    output lo_cal_pkg::tc_t  tc
);
    import lo_cal_pkg::*;

    always_comb begin
        if (mode == MODE_FAST)
            tc = TC_FAST;
        else if (mode == MODE_SLOW)
            tc = TC_SLOW;
        else if (noisy)
            tc = TC_SLOW;
        else if (!in_lock)
            tc = TC_MEDIUM;
        else
            tc = TC_SLOW;
    end
endmodule

// File: rtl/line_osc_cal_seq.sv
module line_osc_cal_seq #(
    parameter int CW_W       = 6,
    parameter int CNT_W      = 10,
    parameter int TARGET_CNT = 432,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int XTAL_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              meas_valid,
    input  logic [CNT_W-1:0]  meas_cnt,
    input  logic              in_lock,
    input  logic              noisy,
    output logic [CW_W-1:0]   ctrl_word,
    output logic              cal_busy,
    output logic [1:0]        tc_sel,
    output logic              loop_open,
    output logic [XTAL_W-1:0] xtal_sel
);
    import lo_cal_pkg::*;

    cal_state_t state;
    tc_t        tc;
    logic       wr_xtal, wr_ctrl, armed;
    logic [1:0] mode;

    lo_cal_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .XTAL_W(XTAL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .armed(armed), .wr_xtal(wr_xtal), .wr_ctrl(wr_ctrl),
        .xtal_sel(xtal_sel), .mode(mode), .loop_open(loop_open)
    );

    lo_cal_fsm #(.CW_W(CW_W), .CNT_W(CNT_W), .TARGET_CNT(TARGET_CNT)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_xtal(wr_xtal), .wr_ctrl(wr_ctrl),
        .meas_valid(meas_valid), .meas_cnt(meas_cnt), .in_lock(in_lock),
        .state(state), .ctrl_word(ctrl_word), .cal_busy(cal_busy), .armed(armed)
    );

    lo_cal_tcsel u_tc (.mode(mode), .noisy(noisy), .in_lock(in_lock), .tc(tc));

    assign tc_sel = tc;
endmodule

// File: rtl/lo_cal_chk.sv
module lo_cal_chk #(
    parameter int CW_W       = 6,
    parameter int CNT_W      = 10,
    parameter int TARGET_CNT = 432,
    parameter int ADDR_W     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              meas_valid,
    input logic [CNT_W-1:0]  meas_cnt,
    input logic              in_lock,
    input logic [CW_W-1:0]   ctrl_word,
    input logic              cal_busy,
    input logic [1:0]        tc_sel,
    input logic [1:0]        st
);
    localparam logic [CW_W-1:0]  SAFE_CW = {CW_W{1'b1}};
    localparam logic [CNT_W-1:0] TGT     = CNT_W'(TARGET_CNT);

    p_safe_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 2'd0 || st == 2'd1) |-> ctrl_word == SAFE_CW);

    p_ctrl_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 2'd0 && wr_stb && wr_addr == ADDR_W'(1)) |=> !cal_busy);

    p_step_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_busy && meas_valid && meas_cnt > TGT && ctrl_word != '0)
        |=> ctrl_word == $past(ctrl_word) - 1'b1);

    p_cal_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_busy && meas_valid && meas_cnt <= TGT) |=> (!cal_busy && $stable(ctrl_word)));

    p_relock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 2'd3 && !in_lock) |=> (cal_busy && ctrl_word == SAFE_CW));

    p_tc_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tc_sel != 2'b11);
endmodule

bind line_osc_cal_seq lo_cal_chk #(
    .CW_W(CW_W), .CNT_W(CNT_W), .TARGET_CNT(TARGET_CNT), .ADDR_W(ADDR_W)
) i_lo_cal_chk (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .meas_valid(meas_valid), .meas_cnt(meas_cnt), .in_lock(in_lock),
    .ctrl_word(ctrl_word), .cal_busy(cal_busy), .tc_sel(tc_sel), .st(state)
);

// File: tb/test_line_osc_cal_seq.sv
module test_line_osc_cal_seq;
    localparam int CW_W = 6, CNT_W = 10, TGT = 432, SAFE = 63, SLOPE = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_stb = 1'b0;
    logic [7:0]       wr_addr = '0;
    logic [7:0]       wr_data = '0;
    logic             meas_valid = 1'b0;
    logic [CNT_W-1:0] meas_cnt = '0;
    logic             in_lock = 1'b0;
    logic             noisy = 1'b0;
    logic [CW_W-1:0]  ctrl_word;
    logic             cal_busy;
    logic [1:0]       tc_sel;
    logic             loop_open;
    logic [1:0]       xtal_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    line_osc_cal_seq i_line_osc_cal_seq (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .meas_valid(meas_valid), .meas_cnt(meas_cnt),
        .in_lock(in_lock), .noisy(noisy), .ctrl_word(ctrl_word),
        .cal_busy(cal_busy), .tc_sel(tc_sel), .loop_open(loop_open),
        .xtal_sel(xtal_sel)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        wr_stb = 1'b1; wr_addr = 8'(addr); wr_data = 8'(data);
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    function automatic int exp_final(input int base);
        int c;
        if (base > TGT) return 0;
        c = (TGT - base) / SLOPE;
        return (c > SAFE) ? SAFE : c;
    endfunction

    task automatic run_cal(input int base);
        int prev;
        int m;
        for (int i = 0; i < 80 && cal_busy; i++) begin
            prev = ctrl_word;
            m = base + SLOPE * prev;
            meas_valid = 1'b1;
            meas_cnt = CNT_W'(m);
            @(negedge clk);
            if (m > TGT && prev != 0) begin
                chk("R5 step", ctrl_word, prev - 1);
            end else begin
                chk("R6 busy", cal_busy, 0);
                chk("R6 hold", ctrl_word, prev);
            end
        end
        meas_valid = 1'b0;
        chk("R6 final", ctrl_word, exp_final(base));
        chk("R6 idle", cal_busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 word", ctrl_word, SAFE);
        chk("R1 busy", cal_busy, 0);
        chk("R1 open", loop_open, 0);
        chk("R1 xtal", xtal_sel, 0);

        // control write first: must be ignored (fast mode + open)
        wr(1, 8'b101);
        chk("R3 busy", cal_busy, 0);
        chk("R3 word", ctrl_word, SAFE);
        chk("R3 open", loop_open, 0);
        chk("R3 tc", tc_sel, 1);

        wr(0, 2);
        chk("R2 xtal", xtal_sel, 2);
        chk("R2 busy", cal_busy, 0);

        wr(1, 0);
        chk("R4 busy", cal_busy, 1);
        chk("R4 word", ctrl_word, SAFE);
        in_lock = 1'b1;

        for (int b = 100; b <= 460; b += 40) begin
            if (b != 100) begin
                in_lock = 1'b0;
                @(negedge clk);
                in_lock = 1'b1;
                chk("R7 busy", cal_busy, 1);
                chk("R7 word", ctrl_word, SAFE);
            end
            run_cal(b);
        end

        // loss of lock during calibration must not reset the word
        in_lock = 1'b0;
        @(negedge clk);
        in_lock = 1'b1;
        meas_valid = 1'b1; meas_cnt = CNT_W'(TGT + 1);
        @(negedge clk);
        meas_valid = 1'b0;
        in_lock = 1'b0;
        @(negedge clk);
        in_lock = 1'b1;
        chk("R7 cal ignores lock", ctrl_word, SAFE - 1);
        run_cal(TGT - SLOPE * 40);

        // R10/R11: control writes while running
        wr(1, 8'b100);
        chk("R11 no restart", cal_busy, 0);
        chk("R10 open", loop_open, 1);
        wr(1, 8'b000);
        chk("R10 close", loop_open, 0);
        wr(0, 1);
        chk("R11 xtal", xtal_sel, 1);

        // time constant table, exhaustive; lock held high to stay in RUN
        for (int md = 0; md < 4; md++) begin
            wr(1, md);
            chk("R11 no restart", cal_busy, 0);
            for (int nz = 0; nz < 2; nz++) begin
                int e;
                noisy = nz[0];
                @(negedge clk);
                if (md == 1) e = 2;
                else if (md == 2) e = 0;
                else e = 0;
                chk((md == 1 || md == 2) ? "R8 tc" : "R9 tc", tc_sel, e);
            end
        end
        // automatic mode with lock low: medium when clean, slow when noisy
        wr(1, 0);
        in_lock = 1'b0; noisy = 1'b0;
        #1;
        chk("R9 unlocked clean", tc_sel, 1);
        noisy = 1'b1;
        #1;
        chk("R9 unlocked noisy", tc_sel, 0);
        wr(1, 1);
        chk("R8 fast in cal", tc_sel, 2);
        chk("R11 busy from lock", cal_busy, 1);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog actual 0 expected 1");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule